// File: doc/BRIEF.md
# Power-Up Start-Up Reset Sequencer

This block holds the core in reset while power and the system clock settle. Once the external reset request is released, it runs two phases in order. The first phase is a supply-settling time-out measured in ticks of a slow watchdog oscillator. The second phase is an oscillator-stability wait measured in cycles of the selected clock. Only after both phases does it release the core reset, and that release is synchronized to the selected clock.

Two fuse fields set the length of each phase. The clock-select code sets the type of clock source, and that type fixes the stability count. The start-up-time code, together with the clock type, picks the time-out length. All logic runs on the selected oscillator clock. The watchdog tick arrives as a one-cycle enable pulse in that clock domain. The external request resets the block asynchronously, so a new request during either phase restarts the whole sequence.

Top module: `startup_reset_seq`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n` is low without waiting for a clock edge.
- R2: The time-out length in watchdog ticks depends on `sut_fuse`:
  - 00 gives zero ticks, except for the low-frequency crystal (`cksel_fuse` 0110 or 0111), which gets TO_SHORT.
  - 01 gives TO_SHORT.
  - 10 and 11 give TO_LONG.
- R3: The stability count in clock cycles depends on `cksel_fuse`:
  - 0000 (external clock) gives EXT_CYC.
  - 0010 and 0011 (internal RC and slow internal RC) give RC_CYC.
  - 0110 and 0111 (low-frequency crystal) give LF_CYC.
  - Any code with bit 3 set (low-power crystal) gives XTAL_CYC.
- R4: The reserved clock-select codes 0001, 0100 and 0101 use the largest of the four stability counts.
- R5: Number the first rising clock edge after `ext_rst_n` goes high as edge 0, and let T be the time-out count and N the stability count. Then:
  - Ticks are counted only from edge 2 onward.
  - The stability phase starts on the edge after the T-th counted tick, or on edge 2 when T is zero.
  - `core_rst_n` rises N+2 edges after the stability phase starts.
- R6: Asserting `ext_rst_n` during either phase aborts the sequence. After the next release, the full sequence runs again from the time-out phase.
- R7: Once `core_rst_n` is high, it stays high until `ext_rst_n` goes low.
- R8: Watchdog ticks have no effect outside the time-out phase. This covers ticks in the first two edges after release and ticks after the time-out ends.
- R9: The factory default fuses (`cksel_fuse` 0010, `sut_fuse` 10) select the long time-out and the RC stability count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Selected oscillator clock |
| ext_rst_n | input | 1 | Combined external reset request, active low, asynchronous |
| wdt_tick | input | 1 | One-cycle watchdog-oscillator tick, synchronous to `clk_osc` |
| cksel_fuse | input | 4 | Clock-select fuse code |
| sut_fuse | input | 2 | Start-up-time fuse code |
| core_rst_n | output | 1 | Synchronized core reset, active low |

## Verification
The assertions check these rules on every clock cycle:
- The core reset is held low while the request is active.
- Once the core reset is released, it stays released.
- The stability phase never ends before the time-out phase.
- The release comes exactly two cycles after the stability phase ends.
- The stability phase lasts as many cycles as the decoded count.

Only the bench scenarios can show that each fuse code maps to the right time-out and stability lengths, and that the release lands on the exact edge worked out from the tick spacing. The same holds for stray ticks having no effect, and for an aborted sequence restarting at full length.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    CK_EXT,
    CK_RC,
    CK_LF,
    CK_XTAL,
    CK_RSVD
  } clk_kind_e;

  function automatic clk_kind_e kind_of(input logic [3:0] cs);
    clk_kind_e k;
    if (cs[3]) begin
      k = CK_XTAL;
    end else begin
      case (cs[2:0])
        3'b000:         k = CK_EXT;
        3'b010, 3'b011: k = CK_RC;
        3'b110, 3'b111: k = CK_LF;
        default:        k = CK_RSVD;
      endcase
    end
    return k;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srs_sync.sv
// Multi-stage synchronizer with asynchronous clear.
module srs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/srs_fuse_decode.sv
// Maps fuse codes to phase lengths.
module srs_fuse_decode
  import srs_pkg::*;
#(
  parameter int TO_SHORT = 4,
  parameter int TO_LONG  = 64,
  parameter int EXT_CYC  = 6,
  parameter int RC_CYC   = 6,
  parameter int XTAL_CYC = 1024,
  parameter int LF_CYC   = 32768,
  parameter int TOW      = 7,
  parameter int SCW      = 16
) (
  input  logic [3:0]     cksel,
  input  logic [1:0]     sut,
  output logic [TOW-1:0] to_ticks,
  output logic [SCW-1:0] stab_len
);
  localparam int STAB_MAX = max2(max2(EXT_CYC, RC_CYC), max2(XTAL_CYC, LF_CYC));

  clk_kind_e kind;

  always_comb begin
    kind = kind_of(cksel);

    case (sut)
      2'b00:   to_ticks = (kind == CK_LF) ? TOW'(TO_SHORT) : '0;
      2'b01:   to_ticks = TOW'(TO_SHORT);
      default: to_ticks = TOW'(TO_LONG);
    endcase

    case (kind)
      CK_EXT:  stab_len = SCW'(EXT_CYC);
      CK_RC:   stab_len = SCW'(RC_CYC);
      CK_LF:   stab_len = SCW'(LF_CYC);
      CK_XTAL: stab_len = SCW'(XTAL_CYC);
      default: stab_len = SCW'(STAB_MAX);
    endcase
  end
endmodule

// File: rtl/srs_timeout.sv
// Supply-settling phase: counts watchdog ticks up to the target.
module srs_timeout #(
  parameter int TOW = 7
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           en,
  input  logic           tick,
  input  logic [TOW-1:0] target,
  output logic           done
);
  logic [TOW-1:0] cnt_q, cnt_d;
  logic           done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (en && !done_q) begin
      if (cnt_q == target) done_d = 1'b1;
      else if (tick)       cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/srs_stab_count.sv
// Oscillator-stability phase: counts clock cycles after the time-out.
module srs_stab_count #(
  parameter int SCW = 16
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           start,
  input  logic [SCW-1:0] len,
  output logic           done
);
  logic [SCW-1:0] cnt_q, cnt_d;
  logic           done_q, done_d;
  logic [SCW-1:0] last;

  always_comb begin
    last   = len - 1'b1;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (start && !done_q) begin
      if (cnt_q == last) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/startup_reset_seq.sv
module startup_reset_seq
  import srs_pkg::*;
#(
  parameter int TO_SHORT = 4,
  parameter int TO_LONG  = 64,
  parameter int EXT_CYC  = 6,
  parameter int RC_CYC   = 6,
  parameter int XTAL_CYC = 1024,
  parameter int LF_CYC   = 32768,
  parameter int SYNC_STG = 2
) (
  input  logic       clk_osc,
  input  logic       ext_rst_n,
  input  logic       wdt_tick,
  input  logic [3:0] cksel_fuse,
  input  logic [1:0] sut_fuse,
  output logic       core_rst_n
);
  localparam int STAB_MAX = max2(max2(EXT_CYC, RC_CYC), max2(XTAL_CYC, LF_CYC));
  localparam int TOW      = $clog2(max2(TO_SHORT, TO_LONG) + 1);
  localparam int SCW      = $clog2(STAB_MAX + 1);

  logic           srst_n;
  logic [TOW-1:0] to_ticks;
  logic [SCW-1:0] stab_len;
  logic           to_done;
  logic           stab_done;

  // Request release is brought into the clock domain before any counting.
  srs_sync #(.STAGES(SYNC_STG)) u_in_sync (
    .clk(clk_osc), .arst_n(ext_rst_n), .d(1'b1), .q(srst_n)
  );

  srs_fuse_decode #(
    .TO_SHORT(TO_SHORT), .TO_LONG(TO_LONG), .EXT_CYC(EXT_CYC), .RC_CYC(RC_CYC),
    .XTAL_CYC(XTAL_CYC), .LF_CYC(LF_CYC), .TOW(TOW), .SCW(SCW)
  ) u_dec (
    .cksel(cksel_fuse), .sut(sut_fuse), .to_ticks(to_ticks), .stab_len(stab_len)
  );

  srs_timeout #(.TOW(TOW)) u_to (
    .clk(clk_osc), .arst_n(ext_rst_n), .en(srst_n), .tick(wdt_tick),
    .target(to_ticks), .done(to_done)
  );

  srs_stab_count #(.SCW(SCW)) u_stab (
    .clk(clk_osc), .arst_n(ext_rst_n), .start(to_done), .len(stab_len),
    .done(stab_done)
  );

  // Release goes out through its own synchronizer stages.
  srs_sync #(.STAGES(SYNC_STG)) u_out_sync (
    .clk(clk_osc), .arst_n(ext_rst_n), .d(stab_done), .q(core_rst_n)
  );
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int SCW = 16
) (
  input logic           clk,
  input logic           ext_rst_n,
  input logic           core_rst_n,
  input logic           to_done,
  input logic           stab_done,
  input logic [SCW-1:0] stab_len
);
  logic [SCW-1:0] ph_cnt;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n)                ph_cnt <= '0;
    else if (to_done && !stab_done) ph_cnt <= ph_cnt + 1'b1;
  end

  a_r1_low_in_reset: assert property (@(posedge clk)
    !ext_rst_n |-> !core_rst_n);

  a_r7_hold_release: assert property (@(posedge clk) disable iff (!ext_rst_n)
    core_rst_n |=> core_rst_n);

  a_r2_timeout_sticky: assert property (@(posedge clk) disable iff (!ext_rst_n)
    to_done |=> to_done);

  a_r3_stab_after_timeout: assert property (@(posedge clk) disable iff (!ext_rst_n)
    stab_done |-> to_done);

  a_r3_stab_length: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(stab_done) |-> (ph_cnt == stab_len));

  a_r5_release_lag: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> $past(stab_done, 2));
endmodule

bind startup_reset_seq srs_checker #(.SCW(SCW)) u_chk (
  .clk(clk_osc), .ext_rst_n(ext_rst_n), .core_rst_n(core_rst_n),
  .to_done(to_done), .stab_done(stab_done), .stab_len(stab_len)
);

// File: tb/sim_startup_reset_seq.sv
module sim_startup_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P_SHORT = 3;
  localparam int P_LONG  = 7;
  localparam int P_EXT   = 6;
  localparam int P_RC    = 5;
  localparam int P_XTAL  = 20;
  localparam int P_LF    = 40;

  logic       clk = 1'b0;
  logic       ext_rst_n;
  logic       wdt_tick;
  logic [3:0] cksel;
  logic [1:0] sut;
  logic       core_rst_n;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  startup_reset_seq #(
    .TO_SHORT(P_SHORT), .TO_LONG(P_LONG), .EXT_CYC(P_EXT), .RC_CYC(P_RC),
    .XTAL_CYC(P_XTAL), .LF_CYC(P_LF), .SYNC_STG(2)
  ) u0 (
    .clk_osc(clk), .ext_rst_n(ext_rst_n), .wdt_tick(wdt_tick),
    .cksel_fuse(cksel), .sut_fuse(sut), .core_rst_n(core_rst_n)
  );

  function automatic int exp_timeout(input logic [3:0] cs, input logic [1:0] su);
    if (su == 2'b00) return (cs == 4'b0110 || cs == 4'b0111) ? P_SHORT : 0;
    if (su == 2'b01) return P_SHORT;
    return P_LONG;
  endfunction

  function automatic int exp_stab(input logic [3:0] cs);
    if (cs >= 4'b1000) return P_XTAL;
    if (cs == 4'b0000) return P_EXT;
    if (cs == 4'b0010 || cs == 4'b0011) return P_RC;
    return P_LF; // 0110/0111, and reserved codes take the largest
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sequence: hold reset, release, count edges, sample after each edge.
  task automatic run_case(input logic [3:0] cs, input logic [1:0] su, input int tper,
                          input int abort_at, input string tag);
    int  t_exp, n_exp, r_exp, first_hi;
    @(negedge clk);
    ext_rst_n = 1'b0; wdt_tick = 1'b0; cksel = cs; sut = su;
    repeat (3) @(negedge clk);
    check(core_rst_n == 1'b0, "R1", core_rst_n, 0);
    t_exp = exp_timeout(cs, su);
    n_exp = exp_stab(cs);
    r_exp = t_exp * tper + n_exp + 4;
    first_hi = -1;
    ext_rst_n = 1'b1;
    for (int e = 0; e <= r_exp + 3; e++) begin
      // R8: ticks before edge 2 and after the time-out must not matter
      wdt_tick = (e < 2) ? 1'b1 : (((e - 2) % tper) == tper - 1);
      @(posedge clk);
      @(negedge clk);
      if (core_rst_n && first_hi < 0) first_hi = e;
      if (abort_at >= 0 && e == abort_at) begin
        ext_rst_n = 1'b0;
        #1;
        check(core_rst_n == 1'b0, "R6", core_rst_n, 0);
        wdt_tick = 1'b0;
        return;
      end
      if (e == r_exp + 3) check(core_rst_n == 1'b1, "R7", core_rst_n, 1);
    end
    // R5 timing with the per-case length requirement
    check(first_hi == r_exp, tag, first_hi, r_exp);
    wdt_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ext_rst_n = 1'b0;
    wdt_tick  = 1'b0;
    cksel     = 4'b0010;
    sut       = 2'b10;
    repeat (2) @(negedge clk);
    check(core_rst_n == 1'b0, "R1", core_rst_n, 0);

    // Directed corners
    run_case(4'b0010, 2'b10, 2, -1, "R9");
    run_case(4'b0000, 2'b00, 1, -1, "R2");
    run_case(4'b0000, 2'b01, 3, -1, "R3");
    run_case(4'b0011, 2'b11, 1, -1, "R2");
    run_case(4'b0110, 2'b00, 2, -1, "R2");
    run_case(4'b0111, 2'b01, 1, -1, "R3");
    run_case(4'b1010, 2'b10, 4, -1, "R3");
    run_case(4'b1111, 2'b00, 1, -1, "R3");
    run_case(4'b0001, 2'b00, 1, -1, "R4");
    run_case(4'b0100, 2'b01, 2, -1, "R4");
    run_case(4'b0101, 2'b10, 1, -1, "R4");
    // Abort in the time-out phase, then in the stability phase, then rerun
    run_case(4'b0010, 2'b10, 3, 6, "R6");
    run_case(4'b0010, 2'b10, 3, -1, "R6");
    run_case(4'b1000, 2'b00, 1, 12, "R6");
    run_case(4'b1000, 2'b00, 1, -1, "R6");

    // Constrained random
    for (int i = 0; i < 24; i++) begin
      logic [3:0] cs;
      logic [1:0] su;
      int         tp, ab, rr;
      cs = 4'($urandom_range(0, 15));
      su = 2'($urandom_range(0, 3));
      tp = $urandom_range(1, 4);
      rr = exp_timeout(cs, su) * tp + exp_stab(cs) + 4;
      ab = ($urandom_range(0, 3) == 0) ? $urandom_range(0, rr - 2) : -1;
      run_case(cs, su, tp, ab, "R5");
      if (ab >= 0) run_case(cs, su, tp, -1, "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule